// File: doc/BRIEF.md
# Serial Sticky Digit Collector

This block builds the sticky bit of a sequential decimal multiplier one BCD digit at a time. As the multiplier iterates, the digit leaving the round-digit position of the product register becomes final. The collector ORs that digit into a running sticky flag, and a down-counter decides how many such digits belong below the round digit. Because of this, the rounding logic never needs a wide OR over the shifted product.

A start pulse clears the flag and loads the counter. The control logic computes the count ahead of time from the operands' leading-zero counts: the precision minus their sum. The count is taken as a two's-complement value, so a negative result behaves as zero. Each iteration strobe then presents one digit. Once the counter runs out, the done flag rises and later digits no longer change the sticky result.

Top module: `sticky_collector`

## Requirements
- R1: After reset, `sticky` and `done` are both 0.
- R2: A cycle with `start` high clears `sticky` and loads the counter from `count_in`. A digit presented in that same cycle is not collected, even when `dig_valid` is high.
- R3: `count_in` is two's complement, and any value of zero or less loads as zero. After such a start, `done` is 1 and `sticky` is 0 from the next cycle on.
- R4: While the counter is nonzero, each cycle with `dig_valid` high and `start` low decrements the counter. In that cycle a digit with any of its 4 bits set makes `sticky` 1. A digit 0000 leaves `sticky` unchanged.
- R5: `done` becomes 1 on the clock edge that collects the last counted digit. That edge also updates `sticky` with that digit.
- R6: Cycles with `dig_valid` low, and any digit offered after `done` is set, change neither `sticky` nor `done`.
- R7: A `start` during an unfinished collection abandons it. A new collection begins with `sticky` cleared and the new count.
- R8: After a start with count N > 0, once N valid digits have been presented, `sticky` is the OR over those N digits of "digit nonzero".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new collection |
| count_in | input | CW | Signed number of digits to collect |
| dig_valid | input | 1 | Iteration strobe: `dig_in` holds a final digit |
| dig_in | input | 4 | BCD digit from the round-digit position |
| sticky | output | 1 | Running OR of the collected digits |
| done | output | 1 | Collection complete |

## Verification
A counter that is wrong by one shows at the ports within one strobe. `done` rises a digit early or late, and a nonzero digit placed just past the boundary then appears in `sticky` or goes missing. The sweep places a single nonzero digit at every position, for every count, so any boundary error shows on the strobe where it happens. A load that treats a negative count as large shows on the first cycle, because `done` then stays low.

// File: rtl/sticky_collector.sv
module sticky_collector #(
  parameter int DIGITS = 16,
  localparam int CW = $clog2(DIGITS + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] count_in,
  input  logic          dig_valid,
  input  logic [3:0]    dig_in,
  output logic          sticky,
  output logic          done
);
  logic [CW-2:0] cnt;
  logic [CW-2:0] load_val;
  logic          take;

  assign load_val = count_in[CW-1] ? '0 : count_in[CW-2:0];
  assign take     = dig_valid && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      sticky <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      cnt    <= load_val;
      sticky <= 1'b0;
      done   <= (load_val == '0);
    end else if (take) begin
      cnt    <= cnt - 1'b1;
      sticky <= sticky | (|dig_in);
      done   <= (cnt == 1);
    end
  end
endmodule

module sticky_collector_chk #(
  parameter int DIGITS = 16,
  localparam int CW = $clog2(DIGITS + 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] count_in,
  input logic          dig_valid,
  input logic [3:0]    dig_in,
  input logic          sticky,
  input logic          done
);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sticky);

  // R3
  nonpos_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (count_in[CW-1] || count_in == '0)) |=> done);

  // R4
  sticky_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky) |-> $past(dig_valid && !start && dig_in != 4'd0));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(sticky)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !dig_valid) |=> ($stable(sticky) && $stable(done)));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !count_in[CW-1] && count_in != '0) |=> !done);
endmodule

bind sticky_collector sticky_collector_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/sticky_collector_bench.sv
module sticky_collector_bench;
  localparam int DIGITS = 4;
  localparam int CW = $clog2(DIGITS + 1) + 1;

  logic clk = 0, rst_n = 0, start = 0, dig_valid = 0;
  logic [CW-1:0] count_in = '0;
  logic [3:0] dig_in = '0;
  logic sticky, done;
  int total = 0, bad = 0;
  int rem;
  logic es, ed;

  always #2 clk = ~clk;

  sticky_collector #(.DIGITS(DIGITS)) u_sticky_collector (.*);

  task automatic check(string req);
    total++;
    if (sticky !== es || done !== ed) begin
      bad++;
      $display("FAIL %s: sticky=%b done=%b expected sticky=%b done=%b",
               req, sticky, done, es, ed);
    end
  endtask

  task automatic cyc(input logic st, input int c, input logic v, input logic [3:0] d);
    @(negedge clk);
    start = st; count_in = CW'(c); dig_valid = v; dig_in = d;
    @(posedge clk);
    #1;
    start = 0; dig_valid = 0;
  endtask

  task automatic do_start(input int c, string req);
    cyc(1, c, 1, 4'd9);
    rem = (c > 0) ? c : 0;
    es = 0; ed = (rem == 0);
    check(req);
  endtask

  task automatic feed(input logic [3:0] d, string req);
    cyc(0, 0, 1, d);
    if (rem > 0) begin
      es = es | (d != 0);
      rem--;
      if (rem == 0) ed = 1;
    end
    check(req);
  endtask

  initial begin
    #40000;
    bad++; total++;
    $display("FAIL watchdog: no finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    es = 0; ed = 0;
    check("R1");
    rst_n = 1;

    for (int c = -3; c <= DIGITS; c++) begin
      for (int pos = -1; pos < DIGITS + 2; pos++) begin
        do_start(c, c <= 0 ? "R3" : "R2");
        for (int k = 0; k < DIGITS + 2; k++) begin
          logic [3:0] d;
          d = (k == pos) ? 4'(1 << (k % 4)) | ((k == 3) ? 4'd9 : 4'd0) : 4'd0;
          feed(d, (k + 1 == c) ? "R5" : (k >= c ? "R6" : "R4"));
          if (k == 1) begin
            cyc(0, 0, 0, 4'd7);
            check("R6");
          end
        end
        total++;
        if (sticky !== (pos >= 0 && pos < c)) begin
          bad++;
          $display("FAIL R8: sticky=%b expected=%b", sticky, (pos >= 0 && pos < c));
        end
      end
    end

    do_start(4, "R2");
    feed(4'd5, "R4");
    feed(4'd0, "R4");
    do_start(2, "R7");
    feed(4'd0, "R7");
    feed(4'd0, "R7");
    feed(4'd8, "R6");

    do_start(3, "R2");
    feed(4'd1, "R4");
    do_start(-1, "R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule